// File: doc/BRIEF.md
# MSI to Indicator-Bit Interrupt Converter

This block turns message-signalled interrupt writes into memory-resident notification bits. Each write that lands in the notify window carries a data word. The upper bits of that word select a function and the low bits name a vector. For an enabled function the block performs two atomic byte OR operations through a simple memory port, in this order:

1. It sets the function's per-vector indicator bit.
2. It sets the function's summary bit.

An adapter interrupt pulse, tagged with the function's interrupt subclass, fires only when the summary bit was clear before the set. Later messages are therefore folded into a single interrupt until software clears the summary bit.

A configuration write port loads the per-function table. Each entry holds an enable, the interrupt subclass, the indicator base and bit offset, and the summary base and bit offset. Two kinds of error event are reported:

- a write whose index names no function;
- a memory operation that fails.

Reads of the window always answer with all ones.

Top module: `msi_ind_notifier`

## Requirements
- R1: An accepted write splits `msi_data` into function index = `msi_data[31:VEC_W]` and vector = `msi_data[VEC_W-1:0]` (VEC_W = 5 by default).
- R2: A write whose index is NFUNC or larger makes no memory access and raises `evt_valid` for one cycle with `evt_code` = 1, `evt_vector` = the vector and `evt_addr` = the zero-extended window offset.
- R3: A write to a function whose enable is 0 makes no memory access, raises no interrupt and posts no event.
- R4: The first memory operation of a transaction targets byte `ind_base + (ind_ofs + vector) / 8` with mask `8'h80 >> ((ind_ofs + vector) % 8)`; `mem_mask` always has exactly one bit set.
- R5: After a successful indicator operation, a second operation targets byte `sum_base + sum_ofs / 8` with mask `8'h80 >> (sum_ofs % 8)`; the vector does not enter the summary position.
- R6: `irq_pulse` is high for one cycle, with `irq_isc` = the function's subclass, exactly when the summary operation completes without error and the returned old byte had the masked bit clear.
- R7: An indicator operation that returns `mem_err` posts an event with `evt_code` = 2 and `evt_addr` = the indicator byte address, then ends the transaction with no summary access and no interrupt.
- R8: A summary operation that returns `mem_err` posts an event with `evt_code` = 2 and `evt_addr` = the summary byte address, and raises no interrupt.
- R9: A read of the window produces `rsp_valid` one cycle after acceptance with `rsp_data` = 32'hFFFFFFFF, and has no other effect.
- R10: After reset every function is disabled; a configuration write replaces all fields of the addressed entry.
- R11: `msi_ready` is low while a memory transaction is in progress; `mem_req`, `mem_addr` and `mem_mask` stay steady until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration entry write strobe |
| cfg_fn | input | FN_W | Entry to write |
| cfg_enable | input | 1 | Function enabled |
| cfg_isc | input | ISC_W | Interrupt subclass |
| cfg_ind_base | input | ADDR_W | Indicator array byte base |
| cfg_ind_ofs | input | OFS_W | Indicator bit offset |
| cfg_sum_base | input | ADDR_W | Summary array byte base |
| cfg_sum_ofs | input | OFS_W | Summary bit offset |
| msi_valid | input | 1 | Window access valid |
| msi_write | input | 1 | 1 = write, 0 = read |
| msi_addr | input | WIN_W | Offset within the notify window |
| msi_data | input | DATA_W | Write data word |
| msi_ready | output | 1 | Access accepted when high |
| rsp_valid | output | 1 | Read response strobe |
| rsp_data | output | DATA_W | Read response data |
| mem_req | output | 1 | Atomic OR request, held until acknowledged |
| mem_addr | output | ADDR_W | Byte address |
| mem_mask | output | 8 | Bits to OR into the byte |
| mem_ack | input | 1 | Operation complete |
| mem_old | input | 8 | Byte value before the OR |
| mem_err | input | 1 | Operation failed |
| irq_pulse | output | 1 | Adapter interrupt pulse |
| irq_isc | output | ISC_W | Subclass of the pulsed interrupt |
| evt_valid | output | 1 | Error event strobe |
| evt_code | output | 2 | 1 = no such function, 2 = indicator access failure |
| evt_vector | output | VEC_W | Vector of the failing write |
| evt_addr | output | ADDR_W | Window offset or failing byte address |

## Verification
The hardest case to reach is a transaction whose indicator operation succeeds while its summary operation fails. No interrupt may follow, yet the indicator bit must remain set. The bench's memory model faults a fixed address range. It then reprograms one function so that its indicator array sits in good memory and its summary byte sits in the faulting range. Interrupt coalescing is also checked: two functions are given neighbouring bits of one summary byte, and the bench clears that byte at chosen points in a sweep over every vector. The expected interrupt for each write is computed from the bench's own image of memory.

// File: rtl/msi_ind_pkg.sv
package msi_ind_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_IND  = 2'd1,
    SEQ_SUM  = 2'd2
  } seq_state_e;

  localparam logic [1:0] EVT_NO_FUNC  = 2'd1;
  localparam logic [1:0] EVT_IND_FAIL = 2'd2;

  localparam logic [7:0] BYTE_MSB = 8'h80;

endpackage

// File: rtl/msi_fn_table.sv
module msi_fn_table #(
  parameter int NFUNC  = 4,
  parameter int FN_W   = 2,
  parameter int ADDR_W = 32,
  parameter int OFS_W  = 16,
  parameter int ISC_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [FN_W-1:0]   cfg_fn,
  input  logic              cfg_enable,
  input  logic [ISC_W-1:0]  cfg_isc,
  input  logic [ADDR_W-1:0] cfg_ind_base,
  input  logic [OFS_W-1:0]  cfg_ind_ofs,
  input  logic [ADDR_W-1:0] cfg_sum_base,
  input  logic [OFS_W-1:0]  cfg_sum_ofs,
  input  logic [FN_W-1:0]   rd_fn,
  output logic              rd_enable,
  output logic [ISC_W-1:0]  rd_isc,
  output logic [ADDR_W-1:0] rd_ind_base,
  output logic [OFS_W-1:0]  rd_ind_ofs,
  output logic [ADDR_W-1:0] rd_sum_base,
  output logic [OFS_W-1:0]  rd_sum_ofs
);

  logic [NFUNC-1:0] en_q;
  logic [ISC_W-1:0]  isc_q      [NFUNC];
  logic [ADDR_W-1:0] ind_base_q [NFUNC];
  logic [OFS_W-1:0]  ind_ofs_q  [NFUNC];
  logic [ADDR_W-1:0] sum_base_q [NFUNC];
  logic [OFS_W-1:0]  sum_ofs_q  [NFUNC];

  for (genvar g = 0; g < NFUNC; g++) begin : g_entry
    logic wr_en;
    assign wr_en = cfg_we && (cfg_fn == FN_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en_q[g]       <= 1'b0;
        isc_q[g]      <= '0;
        ind_base_q[g] <= '0;
        ind_ofs_q[g]  <= '0;
        sum_base_q[g] <= '0;
        sum_ofs_q[g]  <= '0;
      end else if (wr_en) begin
        en_q[g]       <= cfg_enable;
        isc_q[g]      <= cfg_isc;
        ind_base_q[g] <= cfg_ind_base;
        ind_ofs_q[g]  <= cfg_ind_ofs;
        sum_base_q[g] <= cfg_sum_base;
        sum_ofs_q[g]  <= cfg_sum_ofs;
      end
    end
  end

  always_comb begin
    rd_enable   = en_q[rd_fn];
    rd_isc      = isc_q[rd_fn];
    rd_ind_base = ind_base_q[rd_fn];
    rd_ind_ofs  = ind_ofs_q[rd_fn];
    rd_sum_base = sum_base_q[rd_fn];
    rd_sum_ofs  = sum_ofs_q[rd_fn];
  end

endmodule

// File: rtl/msi_bit_locator.sv
module msi_bit_locator #(
  parameter int ADDR_W = 32,
  parameter int OFS_W  = 16,
  parameter int VEC_W  = 5
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [OFS_W-1:0]  ofs,
  input  logic [VEC_W-1:0]  vec,
  output logic [ADDR_W-1:0] byte_addr,
  output logic [7:0]        mask
);
  import msi_ind_pkg::*;

  localparam int BIT_W = ((OFS_W > VEC_W) ? OFS_W : VEC_W) + 1;

  logic [BIT_W-1:0] bit_num;

  always_comb begin
    bit_num   = BIT_W'(ofs) + BIT_W'(vec);
    byte_addr = base + ADDR_W'(bit_num >> 3);
    mask      = BYTE_MSB >> bit_num[2:0];
  end

endmodule

// File: rtl/msi_notify_seq.sv
module msi_notify_seq #(
  parameter int ADDR_W = 32,
  parameter int VEC_W  = 5,
  parameter int ISC_W  = 3,
  parameter int WIN_W  = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              msi_valid,
  input  logic              msi_write,
  input  logic [WIN_W-1:0]  msi_win_addr,
  input  logic [VEC_W-1:0]  msi_vec,
  input  logic              fn_hit,
  input  logic              fn_enable,
  input  logic [ISC_W-1:0]  fn_isc,
  input  logic [ADDR_W-1:0] ind_addr,
  input  logic [7:0]        ind_mask,
  input  logic [ADDR_W-1:0] sum_addr,
  input  logic [7:0]        sum_mask,
  output logic              msi_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_mask,
  input  logic              mem_ack,
  input  logic [7:0]        mem_old,
  input  logic              mem_err,
  output logic              irq_pulse,
  output logic [ISC_W-1:0]  irq_isc,
  output logic              evt_valid,
  output logic [1:0]        evt_code,
  output logic [VEC_W-1:0]  evt_vector,
  output logic [ADDR_W-1:0] evt_addr
);
  import msi_ind_pkg::*;

  seq_state_e state_q, state_d;

  logic [ADDR_W-1:0] ind_addr_q, sum_addr_q;
  logic [7:0]        ind_mask_q, sum_mask_q;
  logic [ISC_W-1:0]  isc_q;
  logic [VEC_W-1:0]  vec_q;
  logic              load_en;

  logic              irq_d, evt_d, rsp_d;
  logic [1:0]        evt_code_d;
  logic [VEC_W-1:0]  evt_vec_d;
  logic [ADDR_W-1:0] evt_addr_d;

  logic              irq_q, evt_q, rsp_q;
  logic [ISC_W-1:0]  irq_isc_q;
  logic [1:0]        evt_code_q;
  logic [VEC_W-1:0]  evt_vec_q;
  logic [ADDR_W-1:0] evt_addr_q;
  logic [DATA_W-1:0] rsp_data_q;

  // next-state and output decisions
  always_comb begin
    state_d    = state_q;
    load_en    = 1'b0;
    irq_d      = 1'b0;
    evt_d      = 1'b0;
    rsp_d      = 1'b0;
    evt_code_d = EVT_NO_FUNC;
    evt_vec_d  = vec_q;
    evt_addr_d = ind_addr_q;
    unique case (state_q)
      SEQ_IDLE: begin
        if (msi_valid) begin
          if (!msi_write) begin
            rsp_d = 1'b1;
          end else if (!fn_hit) begin
            evt_d      = 1'b1;
            evt_code_d = EVT_NO_FUNC;
            evt_vec_d  = msi_vec;
            evt_addr_d = ADDR_W'(msi_win_addr);
          end else if (fn_enable) begin
            load_en = 1'b1;
            state_d = SEQ_IND;
          end
        end
      end
      SEQ_IND: begin
        if (mem_ack) begin
          if (mem_err) begin
            evt_d      = 1'b1;
            evt_code_d = EVT_IND_FAIL;
            evt_addr_d = ind_addr_q;
            state_d    = SEQ_IDLE;
          end else begin
            state_d = SEQ_SUM;
          end
        end
      end
      SEQ_SUM: begin
        if (mem_ack) begin
          state_d = SEQ_IDLE;
          if (mem_err) begin
            evt_d      = 1'b1;
            evt_code_d = EVT_IND_FAIL;
            evt_addr_d = sum_addr_q;
          end else if ((mem_old & sum_mask_q) == 8'h00) begin
            irq_d = 1'b1;
          end
        end
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= SEQ_IDLE;
      irq_q      <= 1'b0;
      evt_q      <= 1'b0;
      rsp_q      <= 1'b0;
      rsp_data_q <= '0;
    end else begin
      state_q    <= state_d;
      irq_q      <= irq_d;
      evt_q      <= evt_d;
      rsp_q      <= rsp_d;
      rsp_data_q <= rsp_d ? {DATA_W{1'b1}} : '0;
    end
  end

  // per-transaction context, loaded on acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ind_addr_q <= '0;
      ind_mask_q <= '0;
      sum_addr_q <= '0;
      sum_mask_q <= '0;
      isc_q      <= '0;
      vec_q      <= '0;
    end else if (load_en) begin
      ind_addr_q <= ind_addr;
      ind_mask_q <= ind_mask;
      sum_addr_q <= sum_addr;
      sum_mask_q <= sum_mask;
      isc_q      <= fn_isc;
      vec_q      <= msi_vec;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_isc_q <= '0;
    end else if (irq_d) begin
      irq_isc_q <= isc_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_code_q <= '0;
      evt_vec_q  <= '0;
      evt_addr_q <= '0;
    end else if (evt_d) begin
      evt_code_q <= evt_code_d;
      evt_vec_q  <= evt_vec_d;
      evt_addr_q <= evt_addr_d;
    end
  end

  assign msi_ready  = (state_q == SEQ_IDLE);
  assign mem_req    = (state_q != SEQ_IDLE);
  assign mem_addr   = (state_q == SEQ_SUM) ? sum_addr_q : ind_addr_q;
  assign mem_mask   = (state_q == SEQ_SUM) ? sum_mask_q : ind_mask_q;
  assign rsp_valid  = rsp_q;
  assign rsp_data   = rsp_data_q;
  assign irq_pulse  = irq_q;
  assign irq_isc    = irq_isc_q;
  assign evt_valid  = evt_q;
  assign evt_code   = evt_code_q;
  assign evt_vector = evt_vec_q;
  assign evt_addr   = evt_addr_q;

endmodule

// File: rtl/msi_ind_notifier.sv
module msi_ind_notifier #(
  parameter int NFUNC  = 4,
  parameter int DATA_W = 32,
  parameter int VEC_W  = 5,
  parameter int ADDR_W = 32,
  parameter int OFS_W  = 16,
  parameter int ISC_W  = 3,
  parameter int WIN_W  = 12,
  localparam int FN_W  = (NFUNC > 1) ? $clog2(NFUNC) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [FN_W-1:0]   cfg_fn,
  input  logic              cfg_enable,
  input  logic [ISC_W-1:0]  cfg_isc,
  input  logic [ADDR_W-1:0] cfg_ind_base,
  input  logic [OFS_W-1:0]  cfg_ind_ofs,
  input  logic [ADDR_W-1:0] cfg_sum_base,
  input  logic [OFS_W-1:0]  cfg_sum_ofs,
  input  logic              msi_valid,
  input  logic              msi_write,
  input  logic [WIN_W-1:0]  msi_addr,
  input  logic [DATA_W-1:0] msi_data,
  output logic              msi_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_mask,
  input  logic              mem_ack,
  input  logic [7:0]        mem_old,
  input  logic              mem_err,
  output logic              irq_pulse,
  output logic [ISC_W-1:0]  irq_isc,
  output logic              evt_valid,
  output logic [1:0]        evt_code,
  output logic [VEC_W-1:0]  evt_vector,
  output logic [ADDR_W-1:0] evt_addr
);

  localparam int IDX_W = DATA_W - VEC_W;

  logic [IDX_W-1:0]  msi_idx;
  logic [VEC_W-1:0]  msi_vec;
  logic              fn_hit;
  logic [FN_W-1:0]   fn_sel;

  logic              tbl_enable;
  logic [ISC_W-1:0]  tbl_isc;
  logic [ADDR_W-1:0] tbl_ind_base, tbl_sum_base;
  logic [OFS_W-1:0]  tbl_ind_ofs, tbl_sum_ofs;

  logic [ADDR_W-1:0] ind_addr, sum_addr;
  logic [7:0]        ind_mask, sum_mask;

  assign msi_idx = msi_data[DATA_W-1:VEC_W];
  assign msi_vec = msi_data[VEC_W-1:0];
  assign fn_hit  = (msi_idx < IDX_W'(NFUNC));
  assign fn_sel  = msi_idx[FN_W-1:0];

  msi_fn_table #(
    .NFUNC(NFUNC), .FN_W(FN_W), .ADDR_W(ADDR_W), .OFS_W(OFS_W), .ISC_W(ISC_W)
  ) u_table (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_we       (cfg_we),
    .cfg_fn       (cfg_fn),
    .cfg_enable   (cfg_enable),
    .cfg_isc      (cfg_isc),
    .cfg_ind_base (cfg_ind_base),
    .cfg_ind_ofs  (cfg_ind_ofs),
    .cfg_sum_base (cfg_sum_base),
    .cfg_sum_ofs  (cfg_sum_ofs),
    .rd_fn        (fn_sel),
    .rd_enable    (tbl_enable),
    .rd_isc       (tbl_isc),
    .rd_ind_base  (tbl_ind_base),
    .rd_ind_ofs   (tbl_ind_ofs),
    .rd_sum_base  (tbl_sum_base),
    .rd_sum_ofs   (tbl_sum_ofs)
  );

  msi_bit_locator #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .VEC_W(VEC_W)) u_ind_loc (
    .base      (tbl_ind_base),
    .ofs       (tbl_ind_ofs),
    .vec       (msi_vec),
    .byte_addr (ind_addr),
    .mask      (ind_mask)
  );

  msi_bit_locator #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .VEC_W(VEC_W)) u_sum_loc (
    .base      (tbl_sum_base),
    .ofs       (tbl_sum_ofs),
    .vec       ({VEC_W{1'b0}}),
    .byte_addr (sum_addr),
    .mask      (sum_mask)
  );

  msi_notify_seq #(
    .ADDR_W(ADDR_W), .VEC_W(VEC_W), .ISC_W(ISC_W), .WIN_W(WIN_W), .DATA_W(DATA_W)
  ) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .msi_valid    (msi_valid),
    .msi_write    (msi_write),
    .msi_win_addr (msi_addr),
    .msi_vec      (msi_vec),
    .fn_hit       (fn_hit),
    .fn_enable    (tbl_enable),
    .fn_isc       (tbl_isc),
    .ind_addr     (ind_addr),
    .ind_mask     (ind_mask),
    .sum_addr     (sum_addr),
    .sum_mask     (sum_mask),
    .msi_ready    (msi_ready),
    .rsp_valid    (rsp_valid),
    .rsp_data     (rsp_data),
    .mem_req      (mem_req),
    .mem_addr     (mem_addr),
    .mem_mask     (mem_mask),
    .mem_ack      (mem_ack),
    .mem_old      (mem_old),
    .mem_err      (mem_err),
    .irq_pulse    (irq_pulse),
    .irq_isc      (irq_isc),
    .evt_valid    (evt_valid),
    .evt_code     (evt_code),
    .evt_vector   (evt_vector),
    .evt_addr     (evt_addr)
  );

endmodule

// File: rtl/msi_ind_notifier_chk.sv
module msi_ind_notifier_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              msi_valid,
  input logic              msi_write,
  input logic              msi_ready,
  input logic              rsp_valid,
  input logic [DATA_W-1:0] rsp_data,
  input logic              mem_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [7:0]        mem_mask,
  input logic              mem_ack,
  input logic              mem_err,
  input logic              irq_pulse,
  input logic              evt_valid,
  input logic [1:0]        evt_code
);

  AST_NOFUNC_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_code == 2'd1) |-> !mem_req);  // R2

  AST_MASK_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> ($countones(mem_mask) == 1));  // R4

  AST_IRQ_AFTER_CLEAN_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> $past(mem_req && mem_ack && !mem_err));  // R6

  AST_IRQ_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |=> !irq_pulse);  // R6

  AST_EVT_IRQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |-> !irq_pulse);  // R7

  AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($past(msi_valid && !msi_write && msi_ready) && rsp_data == {DATA_W{1'b1}}));  // R9

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !msi_ready);  // R11

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_mask)));  // R11

endmodule

bind msi_ind_notifier msi_ind_notifier_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .msi_valid (msi_valid),
  .msi_write (msi_write),
  .msi_ready (msi_ready),
  .rsp_valid (rsp_valid),
  .rsp_data  (rsp_data),
  .mem_req   (mem_req),
  .mem_addr  (mem_addr),
  .mem_mask  (mem_mask),
  .mem_ack   (mem_ack),
  .mem_err   (mem_err),
  .irq_pulse (irq_pulse),
  .evt_valid (evt_valid),
  .evt_code  (evt_code)
);

// File: tb/tb_msi_ind_notifier.sv
`timescale 1ns/1ps
module tb_msi_ind_notifier;

  localparam int VEC_W = 5;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [1:0]  cfg_fn;
  logic        cfg_enable;
  logic [2:0]  cfg_isc;
  logic [31:0] cfg_ind_base, cfg_sum_base;
  logic [15:0] cfg_ind_ofs, cfg_sum_ofs;
  logic        msi_valid, msi_write;
  logic [11:0] msi_addr;
  logic [31:0] msi_data;
  logic        msi_ready, rsp_valid;
  logic [31:0] rsp_data;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic [7:0]  mem_mask;
  logic        mem_ack, mem_err;
  logic [7:0]  mem_old;
  logic        irq_pulse, evt_valid;
  logic [2:0]  irq_isc;
  logic [1:0]  evt_code;
  logic [4:0]  evt_vector;
  logic [31:0] evt_addr;

  msi_ind_notifier dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_fn(cfg_fn), .cfg_enable(cfg_enable), .cfg_isc(cfg_isc),
    .cfg_ind_base(cfg_ind_base), .cfg_ind_ofs(cfg_ind_ofs),
    .cfg_sum_base(cfg_sum_base), .cfg_sum_ofs(cfg_sum_ofs),
    .msi_valid(msi_valid), .msi_write(msi_write), .msi_addr(msi_addr), .msi_data(msi_data),
    .msi_ready(msi_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_mask(mem_mask),
    .mem_ack(mem_ack), .mem_old(mem_old), .mem_err(mem_err),
    .irq_pulse(irq_pulse), .irq_isc(irq_isc),
    .evt_valid(evt_valid), .evt_code(evt_code), .evt_vector(evt_vector), .evt_addr(evt_addr)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int fails  = 0;

  logic [7:0] mem     [256];
  logic [7:0] exp_mem [256];
  logic [7:0] op_addr [4];
  int         op_n;
  logic [7:0] ma;

  int          irq_cnt, evt_cnt, rsp_cnt;
  logic [2:0]  last_isc;
  logic [1:0]  last_code;
  logic [4:0]  last_vec;
  logic [31:0] last_eaddr, last_rsp;

  logic [7:0]  f_ib [4];
  logic [15:0] f_io [4];
  logic [7:0]  f_sb [4];
  logic [15:0] f_so [4];
  logic [2:0]  f_isc [4];

  // memory model: atomic OR returning the old byte; 0xC0..0xFF faults
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ack = 1'b0;
    end else if (mem_ack) begin
      mem_ack = 1'b0;
    end else if (mem_req) begin
      ma = mem_addr[7:0];
      if (op_n < 4) op_addr[op_n] = ma;
      op_n++;
      mem_ack = 1'b1;
      if (ma[7:6] == 2'b11) begin
        mem_err = 1'b1;
        mem_old = 8'h00;
      end else begin
        mem_err = 1'b0;
        mem_old = mem[ma];
        mem[ma] = mem[ma] | mem_mask;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (irq_pulse) begin irq_cnt++; last_isc = irq_isc; end
      if (evt_valid) begin
        evt_cnt++; last_code = evt_code; last_vec = evt_vector; last_eaddr = evt_addr;
      end
      if (rsp_valid) begin rsp_cnt++; last_rsp = rsp_data; end
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int mem_diffs();
    int n = 0;
    for (int i = 0; i < 256; i++) if (mem[i] !== exp_mem[i]) n++;
    return n;
  endfunction

  task automatic cfg(input int fn, input bit en, input logic [2:0] isc,
                     input logic [7:0] ib, input logic [15:0] io,
                     input logic [7:0] sb, input logic [15:0] so);
    @(negedge clk);
    cfg_we = 1'b1; cfg_fn = 2'(fn); cfg_enable = en; cfg_isc = isc;
    cfg_ind_base = 32'(ib); cfg_ind_ofs = io; cfg_sum_base = 32'(sb); cfg_sum_ofs = so;
    f_ib[fn] = ib; f_io[fn] = io; f_sb[fn] = sb; f_so[fn] = so; f_isc[fn] = isc;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic access(input bit wr, input longint idx, input int vec, input logic [11:0] wa);
    op_n = 0;
    @(negedge clk);
    msi_valid = 1'b1; msi_write = wr; msi_addr = wa;
    msi_data = 32'((idx << VEC_W) | longint'(vec));
    @(negedge clk);
    msi_valid = 1'b0;
    while (!msi_ready) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic sweep_one(input int fn, input int vec);
    int bi, bs, i0, e0;
    logic [7:0] ia, im, sa, sm;
    bit exp_irq;
    bi = int'(f_io[fn]) + vec;
    bs = int'(f_so[fn]);
    ia = f_ib[fn] + 8'(bi / 8); im = 8'h80 >> (bi % 8);
    sa = f_sb[fn] + 8'(bs / 8); sm = 8'h80 >> (bs % 8);
    exp_irq = ((exp_mem[sa] & sm) == 8'h00);
    exp_mem[ia] = exp_mem[ia] | im;
    exp_mem[sa] = exp_mem[sa] | sm;
    i0 = irq_cnt; e0 = evt_cnt;
    access(1'b1, longint'(fn), vec, 12'h000);
    chk(op_n == 2 && op_addr[0] == ia, "R1/R4 indicator byte", longint'(op_addr[0]), longint'(ia));
    chk(op_n == 2 && op_addr[1] == sa, "R5 summary byte after indicator", longint'(op_addr[1]), longint'(sa));
    chk(mem_diffs() == 0, "R4/R5 memory image", longint'(mem_diffs()), 0);
    chk((irq_cnt - i0) == int'(exp_irq), "R6 interrupt count", longint'(irq_cnt - i0), longint'(exp_irq));
    if (exp_irq) chk(last_isc == f_isc[fn], "R6 subclass", longint'(last_isc), longint'(f_isc[fn]));
    chk(evt_cnt == e0, "R6 no event on clean write", longint'(evt_cnt - e0), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL R11 watchdog actual=hung expected=complete");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int i0, e0, r0;
    rst_n = 1'b0;
    cfg_we = 0; cfg_fn = 0; cfg_enable = 0; cfg_isc = 0;
    cfg_ind_base = 0; cfg_ind_ofs = 0; cfg_sum_base = 0; cfg_sum_ofs = 0;
    msi_valid = 0; msi_write = 0; msi_addr = 0; msi_data = 0;
    mem_ack = 0; mem_err = 0; mem_old = 0;
    irq_cnt = 0; evt_cnt = 0; rsp_cnt = 0; op_n = 0;
    last_isc = 0; last_code = 0; last_vec = 0; last_eaddr = 0; last_rsp = 0;
    for (int i = 0; i < 256; i++) begin mem[i] = 8'h00; exp_mem[i] = 8'h00; end
    for (int i = 0; i < 4; i++) begin op_addr[i] = 0; f_ib[i] = 0; f_io[i] = 0; f_sb[i] = 0; f_so[i] = 0; f_isc[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    chk(msi_ready == 1'b1, "R11 ready after reset", longint'(msi_ready), 1);
    chk(!irq_pulse && !evt_valid && !mem_req && !rsp_valid, "R10 idle outputs after reset",
        longint'({irq_pulse, evt_valid, mem_req, rsp_valid}), 0);

    // all functions disabled after reset
    i0 = irq_cnt; e0 = evt_cnt;
    access(1'b1, 0, 3, 12'h000);
    chk(op_n == 0 && irq_cnt == i0 && evt_cnt == e0, "R10 write dropped before configuration",
        longint'(op_n), 0);

    cfg(0, 1'b1, 3'd2, 8'h00, 16'd3,  8'h40, 16'd0);
    cfg(1, 1'b1, 3'd5, 8'h10, 16'd13, 8'h40, 16'd1);
    cfg(2, 1'b0, 3'd6, 8'h20, 16'd0,  8'h44, 16'd0);

    // exhaustive vector sweep over two functions sharing one summary byte
    for (int fn = 0; fn < 2; fn++) begin
      for (int v = 0; v < 32; v++) begin
        if (v % 3 == 0) begin mem[8'h40] = 8'h00; exp_mem[8'h40] = 8'h00; end
        sweep_one(fn, v);
      end
    end

    // disabled function
    i0 = irq_cnt; e0 = evt_cnt;
    access(1'b1, 2, 7, 12'h000);
    chk(op_n == 0, "R3 no memory access for disabled function", longint'(op_n), 0);
    chk(irq_cnt == i0 && evt_cnt == e0, "R3 no interrupt or event", longint'(irq_cnt - i0 + evt_cnt - e0), 0);
    chk(mem_diffs() == 0, "R3 memory untouched", longint'(mem_diffs()), 0);

    // index with no function
    e0 = evt_cnt;
    access(1'b1, 4, 19, 12'h123);
    chk(evt_cnt == e0 + 1 && last_code == 2'd1, "R2 no-function event code", longint'(last_code), 1);
    chk(last_vec == 5'd19 && last_eaddr == 32'h123, "R2 event vector and window offset",
        longint'({last_vec, last_eaddr}), longint'({5'd19, 32'h123}));
    chk(op_n == 0, "R2 no memory access", longint'(op_n), 0);
    e0 = evt_cnt;
    access(1'b1, 64'h7FF_FFFF, 0, 12'hFFF);
    chk(evt_cnt == e0 + 1 && last_vec == 5'd0 && last_eaddr == 32'hFFF, "R1/R2 largest index",
        longint'(last_eaddr), 32'hFFF);

    // indicator access fails
    cfg(3, 1'b1, 3'd7, 8'hC0, 16'd0, 8'h48, 16'd2);
    i0 = irq_cnt; e0 = evt_cnt;
    access(1'b1, 3, 5, 12'h000);
    chk(evt_cnt == e0 + 1 && last_code == 2'd2 && last_eaddr == 32'hC0, "R7 indicator failure event",
        longint'(last_eaddr), 32'hC0);
    chk(last_vec == 5'd5, "R7 event vector", longint'(last_vec), 5);
    chk(op_n == 1 && irq_cnt == i0, "R7 no summary access, no interrupt", longint'(op_n), 1);
    chk(mem_diffs() == 0, "R7 memory untouched", longint'(mem_diffs()), 0);

    // summary access fails after indicator succeeds (R10 reconfiguration)
    cfg(3, 1'b1, 3'd7, 8'h30, 16'd4, 8'hD0, 16'd9);
    exp_mem[8'h30] = exp_mem[8'h30] | 8'h02;
    i0 = irq_cnt; e0 = evt_cnt;
    access(1'b1, 3, 2, 12'h000);
    chk(op_n == 2 && op_addr[0] == 8'h30, "R10 reconfigured indicator byte", longint'(op_addr[0]), 8'h30);
    chk(evt_cnt == e0 + 1 && last_code == 2'd2 && last_eaddr == 32'hD1, "R8 summary failure event",
        longint'(last_eaddr), 32'hD1);
    chk(irq_cnt == i0, "R8 no interrupt", longint'(irq_cnt - i0), 0);
    chk(mem_diffs() == 0, "R8 indicator bit kept", longint'(mem_diffs()), 0);

    // read of the window
    r0 = rsp_cnt; i0 = irq_cnt; e0 = evt_cnt;
    access(1'b0, 0, 1, 12'h004);
    chk(rsp_cnt == r0 + 1 && last_rsp == 32'hFFFF_FFFF, "R9 read response", longint'(last_rsp), 32'hFFFF_FFFF);
    chk(op_n == 0 && irq_cnt == i0 && evt_cnt == e0, "R9 read has no side effect", longint'(op_n), 0);
    chk(mem_diffs() == 0, "R9 memory untouched", longint'(mem_diffs()), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule